// File: doc/BRIEF.md
# Parallel DAC Write Sequencer

This block sits on the host side of a dual-channel DAC that has a parallel input. It takes one command at a time on a valid/ready interface. Each command holds a data word, a channel bit, a byte-select flag, gain and buffer control bits, and a load-mode bit. The block turns each command into a timed sequence on the DAC pins: chip select, write strobe, load strobe and the static bus lines. Every minimum interval is given in picoseconds and converted to whole system clocks by rounding up. Any non-zero minimum gets at least one clock. Every pin is driven from a register.

The interface applies back-pressure in a simple way. `cmd_ready` is high only when the sequencer is idle and no clear is pending or running. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` then stays low until the whole sequence is over, including the gap the DAC needs between writes. While `cmd_valid` is high and `cmd_ready` is low, the source must hold the command steady.

A separate request input, `clr_req`, asks for a clear pulse. The block records the request. It issues the pulse only once no write sequence is in progress.

Top module: `dacpar_wr_seq`

## Requirements
- R1: After reset, `dac_cs_n`, `dac_wr_n`, `dac_ldac_n` and `dac_clr_n` are all high and `cmd_ready` is high.
- R2: A command is accepted when `cmd_valid` and `cmd_ready` are both high at a clock edge. `cmd_ready` is low in the next cycle. It stays low until at least ceil(50 ns / clock) cycles after `dac_wr_n` rises.
- R3: Bus encoding. When `cmd_hben`=1, `dac_db` carries `cmd_data[11:8]` zero-extended to 8 bits; when `cmd_hben`=0 it carries `cmd_data[7:0]`. `dac_a0`, `dac_hben`, `dac_gain` and `dac_bufen` copy `cmd_chan`, `cmd_hben`, `cmd_gain` and `cmd_bufen`.
- R4: `dac_a0` changes at least ceil(20 ns) cycles before `dac_wr_n` falls, and never while `dac_wr_n` is low.
- R5: `dac_wr_n` stays low for at least ceil(20 ns) cycles. `dac_cs_n` falls and rises on the same edges as `dac_wr_n`. There is exactly one write strobe per command.
- R6: `dac_db`, `dac_hben`, `dac_gain` and `dac_bufen` are stable for at least ceil(5 ns) cycles before `dac_wr_n` rises. They do not change within ceil(4.5 ns) cycles after it rises, and never while it is low.
- R7: Each fall of `dac_wr_n` comes at least ceil(50 ns) cycles after the previous rise.
- R8: Synchronous mode (`cmd_sync`=1). `dac_ldac_n` falls while `dac_wr_n` is low, at least ceil(5 ns) cycles after `dac_wr_n` falls and at least ceil(5 ns) cycles before it rises. It rises at least ceil(4.5 ns) cycles after `dac_wr_n` rises.
- R9: Asynchronous mode (`cmd_sync`=0). `dac_ldac_n` falls only while `dac_wr_n` is high, at least ceil(4.5 ns) cycles after `dac_wr_n` rises. It is high again before the next fall of `dac_wr_n`.
- R10: In both modes each command gives exactly one low pulse on `dac_ldac_n`, lasting at least ceil(20 ns) cycles.
- R11: A `clr_req` seen at an idle clock edge makes `dac_clr_n` fall within 2 cycles. It stays low for at least ceil(20 ns) cycles.
- R12: A clear requested during a write is held off. `dac_clr_n` does not fall until at least ceil(50 ns) cycles after `dac_wr_n` rises. While `dac_clr_n` is low, `dac_wr_n` and `dac_ldac_n` are high and `cmd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer can take a command |
| cmd_data | input | 12 | Conversion word |
| cmd_chan | input | 1 | Channel address bit |
| cmd_hben | input | 1 | 1: upper bits go on the bus, 0: lower byte |
| cmd_gain | input | 1 | Gain control bit |
| cmd_bufen | input | 1 | Reference buffer control bit |
| cmd_sync | input | 1 | 1: synchronous load, 0: asynchronous load |
| clr_req | input | 1 | Request for a clear pulse |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_wr_n | output | 1 | Write strobe, active low |
| dac_ldac_n | output | 1 | Load strobe, active low |
| dac_clr_n | output | 1 | Clear strobe, active low |
| dac_a0 | output | 1 | Channel address |
| dac_db | output | 8 | Data bus |
| dac_hben | output | 1 | Byte-select line |
| dac_gain | output | 1 | Gain line |
| dac_bufen | output | 1 | Buffer line |

## Verification
The bench measures, in clock cycles, the spacing between every pair of related pin edges. It does this in both load modes and with back-to-back commands. A sequencer that drops the load strobe in the wrong window, or counts one cycle short, is caught by the measured interval. Examples are a synchronous load pulse that falls outside the write strobe, or an asynchronous load pulse that falls while the strobe is still low. A write too close to the previous one and a bus that changes inside the hold window are caught the same way. A clear request placed in the middle of a write tests the deferral: a sequencer that ignores it would pulse the clear line over an active strobe or too soon after one. Both byte-select settings are used, so a swapped byte mux shows up as a wrong bus value at the rising edge of the write strobe.

// File: rtl/dacpar_pkg.sv
package dacpar_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SETUP = 2'd1,
    SQ_WRLO  = 2'd2,
    SQ_POST  = 2'd3
  } seq_st_e;

  typedef struct packed {
    logic a0;
    logic hben;
    logic gain;
    logic bufen;
    logic sync;
  } dac_ctl_t;

  // round a picosecond minimum up to whole clocks; zero stays zero
  function automatic int unsigned ps2cyc(input int unsigned t_ps, input int unsigned clk_ps);
    if (t_ps == 0) return 0;
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacpar_phase_cnt.sv
module dacpar_phase_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] ph
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ph <= '0;
    else if (restart) ph <= '0;
    else              ph <= ph + 1'b1;
  end
endmodule

// File: rtl/dacpar_bus_reg.sv
module dacpar_bus_reg
  import dacpar_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data_i,
  input  dac_ctl_t          ctl_i,
  output logic [BUS_W-1:0]  db_o,
  output dac_ctl_t          ctl_o
);
  localparam int unsigned UP_W = (DATA_W > BUS_W) ? DATA_W - BUS_W : 1;

  logic [BUS_W-1:0] lo_byte, hi_byte, sel_byte;

  assign lo_byte = data_i[BUS_W-1:0];

  generate
    if (DATA_W > BUS_W) begin : g_split
      logic [UP_W-1:0] up_bits;
      assign up_bits = data_i[DATA_W-1:BUS_W];
      assign hi_byte = BUS_W'(up_bits);
    end else begin : g_narrow
      assign hi_byte = lo_byte;
    end
  endgenerate

  assign sel_byte = ctl_i.hben ? hi_byte : lo_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_o  <= '0;
      ctl_o <= '0;
    end else if (load) begin
      db_o  <= sel_byte;
      ctl_o <= ctl_i;
    end
  end
endmodule

// File: rtl/dacpar_clr_gen.sv
module dacpar_clr_gen #(
  parameter int unsigned LOW_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic idle_i,
  output logic pend_o,
  output logic busy_o,
  output logic clr_n
);
  localparam int unsigned LC  = (LOW_CYC < 1) ? 1 : LOW_CYC;
  localparam int unsigned CW  = (LC < 2) ? 1 : $clog2(LC);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
      busy_o <= 1'b0;
      clr_n  <= 1'b1;
      left   <= '0;
    end else begin
      if (!busy_o && pend_o && idle_i) begin
        busy_o <= 1'b1;
        clr_n  <= 1'b0;
        left   <= CW'(LC - 1);
        pend_o <= req;
      end else begin
        if (req) pend_o <= 1'b1;
        if (busy_o) begin
          if (left == '0) begin
            busy_o <= 1'b0;
            clr_n  <= 1'b1;
          end else begin
            left <= left - 1'b1;
          end
        end
      end
    end
  end

  // R12: a pending clear survives until the sequencer is idle
  p_pend_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !idle_i) |=> pend_o);

endmodule

// File: rtl/dacpar_wr_seq.sv
module dacpar_wr_seq
  import dacpar_pkg::*;
#(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned BUS_W     = 8,
  parameter int unsigned CLK_PS    = 10000,
  parameter int unsigned T_WR_PS   = 20000,
  parameter int unsigned T_DSU_PS  = 5000,
  parameter int unsigned T_DH_PS   = 4500,
  parameter int unsigned T_A0SU_PS = 20000,
  parameter int unsigned T_GAP_PS  = 50000,
  parameter int unsigned T_SF_PS   = 5000,
  parameter int unsigned T_SR_PS   = 5000,
  parameter int unsigned T_SH_PS   = 4500,
  parameter int unsigned T_AF_PS   = 4500,
  parameter int unsigned T_LD_PS   = 20000,
  parameter int unsigned T_CLR_PS  = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_chan,
  input  logic              cmd_hben,
  input  logic              cmd_gain,
  input  logic              cmd_bufen,
  input  logic              cmd_sync,
  input  logic              clr_req,
  output logic              dac_cs_n,
  output logic              dac_wr_n,
  output logic              dac_ldac_n,
  output logic              dac_clr_n,
  output logic              dac_a0,
  output logic [BUS_W-1:0]  dac_db,
  output logic              dac_hben,
  output logic              dac_gain,
  output logic              dac_bufen
);
  // cycle counts from the picosecond minimums
  localparam int unsigned C_WR   = ps2cyc(T_WR_PS,   CLK_PS);
  localparam int unsigned C_DSU  = ps2cyc(T_DSU_PS,  CLK_PS);
  localparam int unsigned C_DH   = ps2cyc(T_DH_PS,   CLK_PS);
  localparam int unsigned C_A0SU = ps2cyc(T_A0SU_PS, CLK_PS);
  localparam int unsigned C_GAP  = ps2cyc(T_GAP_PS,  CLK_PS);
  localparam int unsigned C_SF   = ps2cyc(T_SF_PS,   CLK_PS);
  localparam int unsigned C_SR   = ps2cyc(T_SR_PS,   CLK_PS);
  localparam int unsigned C_SH   = ps2cyc(T_SH_PS,   CLK_PS);
  localparam int unsigned C_AF   = ps2cyc(T_AF_PS,   CLK_PS);
  localparam int unsigned C_LD   = ps2cyc(T_LD_PS,   CLK_PS);
  localparam int unsigned C_CLR  = ps2cyc(T_CLR_PS,  CLK_PS);

  // phase lengths
  localparam int unsigned SETUP_LEN = umax(C_A0SU, 1);
  localparam int unsigned SF        = umax(C_SF, 1);
  localparam int unsigned LD        = umax(C_LD, 1);
  localparam int unsigned AF        = umax(C_AF, 1);
  localparam int unsigned WL_SYNC   = umax(umax(C_WR, C_DSU), SF + umax(C_SR, 1));
  localparam int unsigned WL_ASYNC  = umax(umax(C_WR, C_DSU), 1);
  localparam int unsigned LD_IN_WR  = WL_SYNC - SF;
  localparam int unsigned LD_TAIL   = (LD > LD_IN_WR) ? LD - LD_IN_WR : 0;
  localparam int unsigned H_SYNC    = umax(umax(C_SH, 1), LD_TAIL);
  localparam int unsigned PL_SYNC   = umax(umax(C_GAP, C_DH), H_SYNC);
  localparam int unsigned PL_ASYNC  = umax(umax(C_GAP, C_DH), AF + LD);
  localparam int unsigned MAX_LEN   = umax(umax(SETUP_LEN, umax(WL_SYNC, WL_ASYNC)),
                                           umax(PL_SYNC, PL_ASYNC));
  localparam int unsigned PH_W      = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN + 1);

  seq_st_e          st;
  logic [PH_W-1:0]  ph;
  logic             adv;
  logic             accept;
  logic             wr_q, ld_q;
  logic             clr_pend, clr_busy;
  logic             mode_sync;
  logic [PH_W-1:0]  wl_last, pl_last;
  dac_ctl_t         ctl_in, ctl_out;

  assign ctl_in = '{a0: cmd_chan, hben: cmd_hben, gain: cmd_gain,
                    bufen: cmd_bufen, sync: cmd_sync};

  assign cmd_ready = (st == SQ_IDLE) && !clr_pend && !clr_busy;
  assign accept    = cmd_valid && cmd_ready;
  assign mode_sync = ctl_out.sync;
  assign wl_last   = mode_sync ? PH_W'(WL_SYNC - 1) : PH_W'(WL_ASYNC - 1);
  assign pl_last   = mode_sync ? PH_W'(PL_SYNC - 1) : PH_W'(PL_ASYNC - 1);

  always_comb begin
    adv = 1'b0;
    unique case (st)
      SQ_IDLE:  adv = accept;
      SQ_SETUP: adv = (ph == PH_W'(SETUP_LEN - 1));
      SQ_WRLO:  adv = (ph == wl_last);
      SQ_POST:  adv = (ph == pl_last);
      default:  adv = 1'b0;
    endcase
  end

  dacpar_phase_cnt #(.W(PH_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (adv),
    .ph      (ph)
  );

  dacpar_bus_reg #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_bus (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .data_i (cmd_data),
    .ctl_i  (ctl_in),
    .db_o   (dac_db),
    .ctl_o  (ctl_out)
  );

  dacpar_clr_gen #(.LOW_CYC(C_CLR)) u_clr (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (clr_req),
    .idle_i (st == SQ_IDLE),
    .pend_o (clr_pend),
    .busy_o (clr_busy),
    .clr_n  (dac_clr_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SQ_IDLE;
      wr_q <= 1'b1;
      ld_q <= 1'b1;
    end else begin
      unique case (st)
        SQ_IDLE: if (adv) st <= SQ_SETUP;
        SQ_SETUP: if (adv) begin
          st   <= SQ_WRLO;
          wr_q <= 1'b0;
        end
        SQ_WRLO: begin
          if (mode_sync && ph == PH_W'(SF - 1)) ld_q <= 1'b0;
          if (adv) begin
            st   <= SQ_POST;
            wr_q <= 1'b1;
          end
        end
        SQ_POST: begin
          if (mode_sync && ph == PH_W'(H_SYNC - 1))    ld_q <= 1'b1;
          if (!mode_sync && ph == PH_W'(AF - 1))       ld_q <= 1'b0;
          if (!mode_sync && ph == PH_W'(AF + LD - 1))  ld_q <= 1'b1;
          if (adv) st <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign dac_wr_n   = wr_q;
  assign dac_cs_n   = wr_q;
  assign dac_ldac_n = ld_q;
  assign dac_a0     = ctl_out.a0;
  assign dac_hben   = ctl_out.hben;
  assign dac_gain   = ctl_out.gain;
  assign dac_bufen  = ctl_out.bufen;

  // R2: acceptance removes ready in the following cycle
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R6: bus stays put while the strobe is low
  p_db_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |-> $stable(dac_db));

  // R4: address stays put while the strobe is low
  p_a0_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |-> $stable(dac_a0));

  // R8: synchronous load falls inside the write strobe
  p_sync_ld_in_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dac_ldac_n) && mode_sync) |-> !dac_wr_n);

  // R9: asynchronous load falls outside the write strobe
  p_async_ld_out_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dac_ldac_n) && !mode_sync) |-> dac_wr_n);

  // R12: clear never overlaps a write or a load
  p_clr_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_clr_n |-> (dac_wr_n && dac_ldac_n));

endmodule

// File: tb/tb_dacpar_wr_seq.sv
`timescale 1ns/1ps
module tb_dacpar_wr_seq;

  function automatic int cyc_of(input int ps);
    if (ps == 0) return 0;
    return (ps + 9999) / 10000;
  endfunction

  localparam int E_WR   = cyc_of(20000);
  localparam int E_DSU  = cyc_of(5000);
  localparam int E_DH   = cyc_of(4500);
  localparam int E_A0SU = cyc_of(20000);
  localparam int E_GAP  = cyc_of(50000);
  localparam int E_SF   = cyc_of(5000);
  localparam int E_SR   = cyc_of(5000);
  localparam int E_SH   = cyc_of(4500);
  localparam int E_AF   = cyc_of(4500);
  localparam int E_LD   = cyc_of(20000);
  localparam int E_CLR  = cyc_of(20000);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [11:0] cmd_data = '0;
  logic        cmd_chan = 1'b0, cmd_hben = 1'b0, cmd_gain = 1'b0;
  logic        cmd_bufen = 1'b0, cmd_sync = 1'b0, clr_req = 1'b0;
  logic        dac_cs_n, dac_wr_n, dac_ldac_n, dac_clr_n, dac_a0;
  logic [7:0]  dac_db;
  logic        dac_hben, dac_gain, dac_bufen;

  dacpar_wr_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cmd_chan(cmd_chan), .cmd_hben(cmd_hben),
    .cmd_gain(cmd_gain), .cmd_bufen(cmd_bufen), .cmd_sync(cmd_sync),
    .clr_req(clr_req), .dac_cs_n(dac_cs_n), .dac_wr_n(dac_wr_n),
    .dac_ldac_n(dac_ldac_n), .dac_clr_n(dac_clr_n), .dac_a0(dac_a0),
    .dac_db(dac_db), .dac_hben(dac_hben), .dac_gain(dac_gain),
    .dac_bufen(dac_bufen)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expectations set at acceptance
  logic [7:0] exp_db;
  logic       exp_a0, exp_hben, exp_gain, exp_bufen, cur_sync;
  int         acc_cyc = -1000;

  // edge monitor
  bit   mon_en = 1'b0, primed = 1'b0;
  logic p_wr, p_ld, p_clr, p_a0, p_rdy, p_hb, p_gn, p_bf;
  logic [7:0] p_db;
  int t_wr_fall = -1000, t_wr_rise = -1000, t_ld_fall = -1000;
  int t_clr_fall = -1000, t_bus = -1000, t_a0 = -1000;
  int n_wr = 0, n_ld = 0, n_clr = 0;

  always @(negedge clk) begin
    if (mon_en && primed) begin
      if (dac_cs_n !== dac_wr_n)
        chk(1'b0, "R5", "cs_n differs from wr_n", dac_cs_n, dac_wr_n);
      if ({dac_db, dac_hben, dac_gain, dac_bufen} !== {p_db, p_hb, p_gn, p_bf}) begin
        chk(p_wr == 1'b1 && dac_wr_n == 1'b1, "R6", "bus moved with strobe low", 0, 1);
        chk(cyc - t_wr_rise >= E_DH, "R6", "bus hold after wr rise", cyc - t_wr_rise, E_DH);
        t_bus = cyc;
      end
      if (dac_a0 !== p_a0) begin
        chk(p_wr == 1'b1 && dac_wr_n == 1'b1, "R4", "a0 moved with strobe low", 0, 1);
        t_a0 = cyc;
      end
      if (p_wr && !dac_wr_n) begin
        n_wr++;
        chk(cyc - t_wr_rise >= E_GAP, "R7", "write gap", cyc - t_wr_rise, E_GAP);
        chk(cyc - t_a0 >= E_A0SU, "R4", "a0 setup", cyc - t_a0, E_A0SU);
        chk(dac_ldac_n == 1'b1, "R9", "load still low at next write", dac_ldac_n, 1);
        t_wr_fall = cyc;
      end
      if (!p_wr && dac_wr_n) begin
        chk(cyc - t_wr_fall >= E_WR, "R5", "wr low width", cyc - t_wr_fall, E_WR);
        chk(cyc - t_bus >= E_DSU, "R6", "data setup", cyc - t_bus, E_DSU);
        chk(dac_db == exp_db, "R3", "bus value", dac_db, exp_db);
        chk({dac_a0, dac_hben, dac_gain, dac_bufen} == {exp_a0, exp_hben, exp_gain, exp_bufen},
            "R3", "control lines", {dac_a0, dac_hben, dac_gain, dac_bufen},
            {exp_a0, exp_hben, exp_gain, exp_bufen});
        if (cur_sync) begin
          chk(p_ld == 1'b0, "R8", "load low at wr rise", p_ld, 0);
          chk(cyc - t_ld_fall >= E_SR, "R8", "load fall to wr rise", cyc - t_ld_fall, E_SR);
        end
        t_wr_rise = cyc;
      end
      if (p_ld && !dac_ldac_n) begin
        n_ld++;
        if (cur_sync) begin
          chk(dac_wr_n == 1'b0, "R8", "sync load outside strobe", dac_wr_n, 0);
          chk(cyc - t_wr_fall >= E_SF, "R8", "wr fall to load fall", cyc - t_wr_fall, E_SF);
        end else begin
          chk(dac_wr_n == 1'b1, "R9", "async load inside strobe", dac_wr_n, 1);
          chk(cyc - t_wr_rise >= E_AF, "R9", "wr rise to load fall", cyc - t_wr_rise, E_AF);
        end
        t_ld_fall = cyc;
      end
      if (!p_ld && dac_ldac_n) begin
        chk(cyc - t_ld_fall >= E_LD, "R10", "load low width", cyc - t_ld_fall, E_LD);
        if (cur_sync)
          chk(dac_wr_n == 1'b1 && cyc - t_wr_rise >= E_SH, "R8", "load rise after wr rise",
              cyc - t_wr_rise, E_SH);
      end
      if (p_clr && !dac_clr_n) begin
        n_clr++;
        chk(cyc - t_wr_rise >= E_GAP, "R12", "clear too soon after write", cyc - t_wr_rise, E_GAP);
        t_clr_fall = cyc;
      end
      if (!dac_clr_n) begin
        chk(dac_wr_n && dac_ldac_n && !cmd_ready, "R12", "activity during clear",
            {dac_wr_n, dac_ldac_n, cmd_ready}, 3'b110);
      end
      if (!p_clr && dac_clr_n)
        chk(cyc - t_clr_fall >= E_CLR, "R11", "clear low width", cyc - t_clr_fall, E_CLR);
      if (!p_rdy && cmd_ready && t_wr_rise >= 0)
        chk(cyc - t_wr_rise >= E_GAP, "R2", "ready back too early", cyc - t_wr_rise, E_GAP);
    end
    if (mon_en) primed = 1'b1;
    p_wr = dac_wr_n; p_ld = dac_ldac_n; p_clr = dac_clr_n; p_a0 = dac_a0;
    p_rdy = cmd_ready; p_db = dac_db; p_hb = dac_hben; p_gn = dac_gain; p_bf = dac_bufen;
  end

  task automatic t_reset_state();
    chk({dac_cs_n, dac_wr_n, dac_ldac_n, dac_clr_n} == 4'hF, "R1", "strobes after reset",
        {dac_cs_n, dac_wr_n, dac_ldac_n, dac_clr_n}, 4'hF);
    chk(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
  endtask

  task automatic issue(input logic [11:0] d, input logic ch, input logic hb,
                       input logic gn, input logic bf, input logic sy);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = d; cmd_chan = ch; cmd_hben = hb;
    cmd_gain = gn; cmd_bufen = bf; cmd_sync = sy;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    acc_cyc = cyc;
    cur_sync = sy;
    exp_db = hb ? {4'b0000, d[11:8]} : d[7:0];
    exp_a0 = ch; exp_hben = hb; exp_gain = gn; exp_bufen = bf;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R2", "ready after accept", cmd_ready, 0);
  endtask

  task automatic wait_idle();
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic t_write(input logic [11:0] d, input logic ch, input logic hb,
                         input logic gn, input logic bf, input logic sy);
    int w0, l0;
    w0 = n_wr; l0 = n_ld;
    issue(d, ch, hb, gn, bf, sy);
    wait_idle();
    chk(n_wr == w0 + 1, "R5", "write strobes per command", n_wr - w0, 1);
    chk(n_ld == l0 + 1, "R10", "load pulses per command", n_ld - l0, 1);
  endtask

  task automatic t_back_to_back();
    int w0;
    w0 = n_wr;
    issue(12'h5A3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    issue(12'h3C7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    issue(12'h0FF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    wait_idle();
    chk(n_wr == w0 + 3, "R7", "back-to-back write count", n_wr - w0, 3);
  endtask

  task automatic t_clear_idle();
    int c0, req_cyc;
    c0 = n_clr;
    @(negedge clk);
    clr_req = 1'b1;
    @(posedge clk);
    req_cyc = cyc;
    @(negedge clk);
    clr_req = 1'b0;
    repeat (4) @(negedge clk);
    chk(n_clr == c0 + 1, "R11", "clear pulse issued", n_clr - c0, 1);
    chk(t_clr_fall - req_cyc <= 2, "R11", "clear start latency", t_clr_fall - req_cyc, 2);
    wait_idle();
  endtask

  task automatic t_clear_mid_write();
    int c0, w0;
    c0 = n_clr; w0 = n_wr;
    issue(12'hA5C, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    wait_idle();
    chk(n_clr == c0 + 1, "R12", "deferred clear issued", n_clr - c0, 1);
    chk(n_wr == w0 + 1, "R12", "write completed before clear", n_wr - w0, 1);
    chk(t_clr_fall > t_wr_rise, "R12", "clear after write", t_clr_fall, t_wr_rise + 1);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    mon_en = 1'b1;
    @(negedge clk);
    t_write(12'h9B4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);   // sync, low byte
    t_write(12'hABC, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);   // sync, high bits
    t_write(12'h123, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);   // async, low byte
    t_write(12'hF0E, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);   // async, high bits
    t_back_to_back();
    t_clear_idle();
    t_clear_mid_write();
    t_write(12'h7E1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    report();
  end

endmodule